// File: doc/BRIEF.md
# Instruction-Boundary Event Priority Arbiter

This block decides which pending event class a processor core services when it reaches an instruction boundary. Ten event classes are tracked, each with its own pending flag that a source sets with a one-cycle request pulse. When the boundary strobe is high, the arbiter grants exactly one class, the highest-priority one that is pending. It reports that class as a one-hot grant, a class code and a handler vector. One cycle later it raises a handler-start strobe that carries the same vector.

Classes 4 (non-maskable interrupt) and 5 (maskable interrupt) are interrupt classes. When they lose arbitration they stay pending until they are granted. The other eight classes are exception classes. Their flags are cleared at every boundary strobe, and any exception class that was pending but lost is flagged on a discard output in the same cycle. A merge mode input puts both interrupt classes into one shared priority slot. In that mode a maskable grant reports the shared class code, and the non-maskable source still wins inside the slot.

Top module: `evt_prio_arb`

## Requirements
- R1: After reset no class is pending, grant_o, discard_o, cls_o, vec_o and start_o are all zero, and a boundary strobe with nothing pending grants nothing.
- R2: While boundary_i is high and at least one class is pending, grant_o has the bit of the pending class with the lowest index set (index 0 is the highest priority). While boundary_i is low, grant_o is zero.
- R3: grant_o never has more than one bit set.
- R4: In the cycle of a grant, cls_o holds the index of the granted class, 0 to 9.
- R5: The pending flag of an interrupt class (index 4 non-maskable, index 5 maskable) is cleared only by a grant to that class. An interrupt class that loses a boundary is granted at a later boundary.
- R6: At every boundary strobe all exception classes (indices 0 to 3 and 6 to 9) stop being pending. In the same cycle, discard_o has a bit set for each exception class that was pending and was not granted.
- R7: When class 4 is granted, vec_o is 2 and the vector input slot for class 4 is ignored. For any other granted class c, vec_o equals bits [8c+7:8c] of vec_i.
- R8: One clock after a grant, start_o is high for exactly one cycle and start_vec_o holds the vector that was granted.
- R9: With merge_i high, a grant to class 5 reports cls_o = 4, and when classes 4 and 5 are both pending, class 4 is granted first. With merge_i low, class 5 reports cls_o = 5.
- R10: A request that arrives in the same cycle as a boundary strobe plays no part in that boundary. It is not lost, and it is granted at the next boundary. A new request wins over the clear that the boundary makes in the same cycle.
- R11: When no boundary strobe occurs, every pending flag is kept, exception flags included, however many cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| merge_i | input | 1 | Merge the two interrupt classes into one priority slot |
| req_i | input | 10 | Per-class request pulses; bit c sets pending flag c |
| vec_i | input | 80 | Per-class handler vectors, 8 bits per class, class c at [8c+7:8c] |
| grant_o | output | 10 | One-hot grant, valid only while boundary_i is high |
| cls_o | output | 4 | Class code of the granted class |
| vec_o | output | 8 | Handler vector of the granted class |
| discard_o | output | 10 | Exception classes dropped at this boundary |
| start_o | output | 1 | Handler-start strobe, one cycle after a grant |
| start_vec_o | output | 8 | Vector accompanying start_o |

## Verification
A request pulse reaches the pending flags at the next rising edge. grant_o, cls_o, vec_o and discard_o are combinational on those flags and on boundary_i, so they are valid in the cycle of the strobe itself, and start_o with start_vec_o follows one edge later. The bench therefore drives requests and strobes just after a falling edge and checks the grant outputs a moment later in that same low phase. It checks the start strobe after the next falling edge, and so reads every result in the half cycle where it is due and stable.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;

  localparam int NCLS     = 10;
  localparam int CW       = $clog2(NCLS);
  localparam int VW       = 8;
  localparam int IDX_NMI  = 4;
  localparam int IDX_INTR = 5;
  localparam int NMI_VEC  = 2;

  // Mask of the classes that are held (interrupts) rather than dropped.
  function automatic logic [NCLS-1:0] irq_mask();
    logic [NCLS-1:0] m;
    m = '0;
    m[IDX_NMI]  = 1'b1;
    m[IDX_INTR] = 1'b1;
    return m;
  endfunction

  // Isolate the lowest set bit: lowest index is highest priority.
  function automatic logic [NCLS-1:0] first_set(logic [NCLS-1:0] p);
    return p & (~p + 1'b1);
  endfunction

  function automatic logic [CW-1:0] oh_to_idx(logic [NCLS-1:0] oh);
    logic [CW-1:0] r;
    r = '0;
    for (int c = 0; c < NCLS; c++)
      if (oh[c]) r = r | CW'(c);
    return r;
  endfunction

  // Reported class code; in merged mode both interrupts share one slot.
  function automatic logic [CW-1:0] report_code(logic [CW-1:0] idx, logic merged);
    if (merged && idx == CW'(IDX_INTR)) return CW'(IDX_NMI);
    return idx;
  endfunction

endpackage

// File: rtl/evt_pend_bank.sv
module evt_pend_bank
  import evt_arb_pkg::*;
#(
  parameter int N = NCLS,
  parameter logic [N-1:0] HOLD_MASK = irq_mask()
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         boundary_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] grant_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar c = 0; c < N; c++) begin : g_cls
    if (HOLD_MASK[c]) begin : g_hold
      // Interrupt: survives until its own grant; new request wins.
      assign pend_d[c] = req_i[c] | (pend_q[c] & ~grant_i[c]);

      AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && pend_q[c] && !grant_i[c]) |=> pend_q[c]); // R5
      AST_IRQ_CLR_BY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[c] && !grant_i[c]) |=> pend_q[c]); // R5
    end else begin : g_drop
      // Exception: wiped by every boundary; new request wins.
      assign pend_d[c] = req_i[c] | (pend_q[c] & ~boundary_i);

      AST_EXC_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && !req_i[c]) |=> !pend_q[c]); // R6
      AST_EXC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary_i && pend_q[c]) |=> pend_q[c]); // R11
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |=> ((pend_q & $past(req_i)) == $past(req_i))); // R10

  assign pend_o = pend_q;

endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick
  import evt_arb_pkg::*;
#(
  parameter int N = NCLS,
  parameter int W = CW,
  parameter logic [N-1:0] HOLD_MASK = irq_mask()
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         boundary_i,
  input  logic         merge_i,
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] grant_o,
  output logic [W-1:0] cls_o,
  output logic [N-1:0] discard_o
);

  logic [N-1:0] winner;
  logic         any_pend;

  assign any_pend = |pend_i;
  assign winner   = first_set(pend_i);

  always_comb begin
    grant_o   = '0;
    cls_o     = '0;
    discard_o = '0;
    if (boundary_i) begin
      grant_o   = winner;
      cls_o     = report_code(oh_to_idx(winner), merge_i);
      discard_o = pend_i & ~HOLD_MASK & ~winner;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R3
  AST_GRANT_IN_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> boundary_i); // R2
  AST_GRANT_IF_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && any_pend) |-> (grant_o != '0)); // R2
  AST_GRANT_IS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & ~pend_i) == '0)); // R2
  AST_NO_DISCARD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((discard_o & HOLD_MASK) == '0)); // R6

endmodule

// File: rtl/evt_vec_out.sv
module evt_vec_out
  import evt_arb_pkg::*;
#(
  parameter int N = NCLS,
  parameter int V = VW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] grant_i,
  input  logic [N*V-1:0] vec_i,
  output logic [V-1:0] vec_o,
  output logic         start_o,
  output logic [V-1:0] start_vec_o
);

  logic [V-1:0] sel;
  logic         any_grant;

  assign any_grant = |grant_i;

  always_comb begin
    sel = '0;
    for (int c = 0; c < N; c++) begin
      if (grant_i[c]) begin
        if (c == IDX_NMI) sel = sel | V'(NMI_VEC);
        else              sel = sel | vec_i[c*V +: V];
      end
    end
  end

  assign vec_o = sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_o     <= 1'b0;
      start_vec_o <= '0;
    end else begin
      start_o     <= any_grant;
      start_vec_o <= any_grant ? sel : '0;
    end
  end

  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i[IDX_NMI] |-> (vec_o == V'(NMI_VEC))); // R7
  AST_START_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    any_grant |=> (start_o && start_vec_o == $past(vec_o))); // R8
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_grant |=> !start_o); // R8

endmodule

// File: rtl/evt_prio_arb.sv
module evt_prio_arb
  import evt_arb_pkg::*;
#(
  parameter int V = VW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary_i,
  input  logic               merge_i,
  input  logic [NCLS-1:0]    req_i,
  input  logic [NCLS*V-1:0]  vec_i,
  output logic [NCLS-1:0]    grant_o,
  output logic [CW-1:0]      cls_o,
  output logic [V-1:0]       vec_o,
  output logic [NCLS-1:0]    discard_o,
  output logic               start_o,
  output logic [V-1:0]       start_vec_o
);

  localparam logic [NCLS-1:0] HOLD = irq_mask();

  logic [NCLS-1:0] pend;
  logic [NCLS-1:0] grant_w;

  evt_pend_bank #(.N(NCLS), .HOLD_MASK(HOLD)) u_pend (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
    .req_i(req_i), .grant_i(grant_w), .pend_o(pend)
  );

  evt_prio_pick #(.N(NCLS), .W(CW), .HOLD_MASK(HOLD)) u_pick (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .merge_i(merge_i),
    .pend_i(pend), .grant_o(grant_w), .cls_o(cls_o), .discard_o(discard_o)
  );

  evt_vec_out #(.N(NCLS), .V(V)) u_vec (
    .clk(clk), .rst_n(rst_n), .grant_i(grant_w), .vec_i(vec_i),
    .vec_o(vec_o), .start_o(start_o), .start_vec_o(start_vec_o)
  );

  assign grant_o = grant_w;

  AST_MERGED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_i && grant_w[IDX_INTR]) |-> (cls_o == CW'(IDX_NMI))); // R9
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[IDX_NMI]) |-> !grant_w[IDX_INTR]); // R9

endmodule

// File: tb/evt_prio_arb_tb.sv
module evt_prio_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;

  logic clk = 0, rst_n = 0, boundary = 0, merge = 0;
  logic [N-1:0] req = '0;
  logic [N*8-1:0] vec;
  logic [N-1:0] grant, discard;
  logic [3:0] cls;
  logic [7:0] vo, svec;
  logic start;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_prio_arb u_dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .merge_i(merge),
    .req_i(req), .vec_i(vec), .grant_o(grant), .cls_o(cls), .vec_o(vo),
    .discard_o(discard), .start_o(start), .start_vec_o(svec)
  );

  function automatic logic [7:0] slot_vec(int c);
    return 8'h10 + 8'(c * 3);
  endfunction
  function automatic logic [7:0] exp_vec(int c);
    return (c == 4) ? 8'd2 : slot_vec(c);
  endfunction
  localparam logic [N-1:0] EXC = 10'b11_1100_1111;

  initial for (int c = 0; c < N; c++) vec[c*8 +: 8] = (c == 4) ? 8'h55 : slot_vec(c);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      summary();
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0; req = '0; boundary = 0; merge = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic pulse(logic [N-1:0] m);
    req = m; @(posedge clk); @(negedge clk); req = '0;
  endtask

  // Called at a negedge; strobe boundary with optional concurrent request.
  task automatic bnd(string tag, int exp_c, logic [N-1:0] exp_disc,
                     logic [3:0] exp_code, logic [N-1:0] cur_req = '0);
    boundary = 1; req = cur_req; #1;
    if (exp_c < 0) begin
      check({tag, " grant none"}, 32'(grant), 0);
    end else begin
      check({tag, " grant"}, 32'(grant), 32'(1 << exp_c));
      check({tag, " cls"}, 32'(cls), 32'(exp_code));
      check({tag, " vec"}, 32'(vo), 32'(exp_vec(exp_c)));
    end
    check({tag, " discard"}, 32'(discard), 32'(exp_disc));
    @(posedge clk); @(negedge clk); boundary = 0; req = '0; #1;
    check({tag, " start"}, 32'(start), (exp_c < 0) ? 0 : 1);
    if (exp_c >= 0) check({tag, " start_vec"}, 32'(svec), 32'(exp_vec(exp_c)));
    @(negedge clk); #1;
    check({tag, " start one cycle"}, 32'(start), 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(); #1;
    check("R1 grant", 32'(grant), 0);
    check("R1 start", 32'(start), 0);
    check("R1 discard", 32'(discard), 0);
    check("R1 cls", 32'(cls), 0);
    check("R1 vec", 32'(vo), 0);
    @(negedge clk);
    bnd("R1 empty boundary", -1, '0, 0);
  endtask

  task automatic t_single();
    for (int c = 0; c < N; c++) begin
      do_reset();
      pulse(N'(1 << c));
      bnd($sformatf("R2 R4 R7 R8 single c%0d", c), c, '0, 4'(c));
    end
  endtask

  task automatic t_all();
    do_reset();
    pulse('1);
    bnd("R2 R6 all pending", 0, EXC & ~10'b1, 0);
    bnd("R5 nmi held", 4, '0, 4);
    bnd("R5 intr held", 5, '0, 5);
    bnd("R6 nothing left", -1, '0, 0);
  endtask

  task automatic t_loss();
    do_reset();
    pulse(10'b00_0010_1000);
    bnd("R5 intr loses to c3", 3, '0, 3);
    bnd("R5 intr later", 5, '0, 5);
    pulse(10'b10_1000_0000);
    bnd("R6 c9 discarded", 7, 10'b10_0000_0000, 7);
    bnd("R6 c9 gone", -1, '0, 0);
  endtask

  task automatic t_idle();
    do_reset();
    pulse(10'b01_0000_0000);
    for (int k = 0; k < 5; k++) begin
      #1; check("R2 R11 idle no grant", 32'(grant), 0);
      @(negedge clk);
    end
    bnd("R11 exc kept", 8, '0, 8);
  endtask

  task automatic t_merge();
    do_reset();
    merge = 1;
    pulse(10'b00_0011_0000);
    bnd("R9 merged nmi first", 4, '0, 4);
    bnd("R9 merged intr code", 5, '0, 4);
    merge = 0;
    pulse(10'b00_0010_0000);
    bnd("R9 split intr code", 5, '0, 5);
  endtask

  task automatic t_same();
    do_reset();
    pulse(10'b00_0100_0000);
    bnd("R10 concurrent c9 ignored", 6, '0, 6, 10'b10_0000_0000);
    bnd("R10 c9 next", 9, '0, 9);
    pulse(10'b00_0010_0000);
    bnd("R10 intr rerequest", 5, '0, 5, 10'b00_0010_0000);
    bnd("R10 intr again", 5, '0, 5);
  endtask

  initial begin
    t_reset();
    t_single();
    t_all();
    t_loss();
    t_idle();
    t_merge();
    t_same();
    summary();
  end
endmodule